// File: doc/BRIEF.md
# One-Time-Programmable Array Byte Writer

This block takes an image for a one-time-programmable code array and writes it one byte at a time through a parallel programming port. A host offers each byte with a valid/ready handshake. The byte carries a 13-bit target address, the data value and a flag that marks the final byte of the image. For every accepted byte the block sets up the port in a fixed order. It drives the address, then the data, then the programming mode pattern, and only after that does it raise the high-voltage enable. After a settle wait it fires a short fixed burst of program strobes.

Once the burst ends, the block removes the high voltage and returns the mode pins to idle. It then switches the port into read-back mode and compares the byte the array returns against the byte it wrote. If the values match, the block accepts the next byte, or it raises `done` when that byte was the last one. If they differ, it raises `err`, reports the failing address and stops until reset. The address is split into a low group of 8 bits and a high group of 5 bits, and both groups stay unchanged for the whole program-and-verify cycle of a byte.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `in_ready`=1, `mode`=4'b0000 (idle), and `hv_en`, `pgm_strobe`, `pd_oe`, `done` and `err` are all 0.
- R2: A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until that byte's verify finishes. `addr_lo` carries address bits [7:0] and `addr_hi` carries bits [12:8]. Both stay unchanged for the whole cycle, and host inputs presented while the block is busy have no effect.
- R3: After a byte is accepted, the address is driven alone for one cycle. Next, `pd_oe`=1 with `pd_out` equal to the data for one cycle. Next, `mode`=4'b0101 (program) for one cycle. Only then does `hv_en` rise.
- R4: `hv_en` stays high for SETTLE_CYC cycles with no strobe before the first strobe starts.
- R5: Exactly NUM_PULSES (default 5) strobes are issued per byte. Each is PULSE_CYC cycles high and is followed by GAP_CYC low cycles, during which `hv_en` stays 1.
- R6: After the last gap, `hv_en` falls for one cycle while `mode` is still program. On the next cycle `mode` returns to idle and `pd_oe` goes to 0.
- R7: Read-back then holds `mode`=4'b1010 (verify) for READ_CYC cycles with `hv_en`=0 and `pd_oe`=0. `pd_in` is compared on the final cycle of that window.
- R8: On a match the block returns to ready, or it raises `done` if the byte was flagged last. `done` holds with `in_ready`=0 and no further strobes until reset.
- R9: On a mismatch the block raises `err` with `err_addr` equal to the byte's address. After that it stays stopped until reset, with no strobes, no high voltage and `in_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block can take a byte |
| in_addr | input | 13 | Target address of the offered byte |
| in_data | input | 8 | Value to write |
| in_last | input | 1 | Offered byte ends the image |
| addr_lo | output | 8 | Address bits [7:0] to the array |
| addr_hi | output | 5 | Address bits [12:8] to the array |
| pd_out | output | 8 | Data driven onto the array data bus |
| pd_oe | output | 1 | Data bus driven by the block |
| pd_in | input | 8 | Byte read back from the array |
| mode | output | 4 | Mode pin pattern: idle, program or verify |
| hv_en | output | 1 | Enable for the external programming-voltage switch |
| pgm_strobe | output | 1 | Program strobe, active high |
| done | output | 1 | Whole image written and verified |
| err | output | 1 | Read-back mismatch seen; block stopped |
| err_addr | output | 13 | Address of the failing byte while `err` is 1 |

## Verification
The bench checks every cycle of each byte against a per-phase expectation. An off-by-one in the settle, strobe or gap counters shows up as a phase that is one cycle too long or too short, and a burst of four or six strobes shows up as a strobe or gap phase that lands in the wrong place. It targets the edges of the address split at 0x0000 and 0x1FFF, where a design that swapped or truncated the high group would drive the wrong bits. It holds junk on the host inputs during a busy byte; a design that latched input while busy would show a changed address. It also corrupts a single bit of read-back data, which a design that skipped the compare would sail past instead of stopping with the failing address.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    localparam int MODE_W = 4;

    // Mode pin patterns presented to the array
    localparam logic [MODE_W-1:0] MODE_IDLE = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_PROG = 4'b0101;
    localparam logic [MODE_W-1:0] MODE_VFY  = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_CTRL,
        ST_SETTLE,
        ST_PULSE,
        ST_GAP,
        ST_HV_DROP,
        ST_QUIET,
        ST_VFY,
        ST_DONE,
        ST_ERR
    } seq_state_e;

endpackage

// File: rtl/otp_step_timer.sv
// Loadable down-counter: holds a phase for (load_val + 1) cycles.
module otp_step_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/otp_pulse_tally.sv
// Counts strobes already finished within the current burst.
module otp_pulse_tally #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (bump) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == W'(N - 1));

endmodule

// File: rtl/otp_readback_cmp.sv
// Bitwise read-back comparison.
module otp_readback_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] expected,
    input  logic [W-1:0] observed,
    output logic         match
);

    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = expected[i] ^ observed[i];
    end

    assign match = (diff == '0);

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int ADDR_LO_W  = 8,
    parameter int DATA_W     = 8,
    parameter int NUM_PULSES = 5,
    parameter int SETTLE_CYC = 16,
    parameter int PULSE_CYC  = 10,
    parameter int GAP_CYC    = 4,
    parameter int READ_CYC   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [ADDR_W-1:0]           in_addr,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_last,
    output logic [ADDR_LO_W-1:0]        addr_lo,
    output logic [ADDR_W-ADDR_LO_W-1:0] addr_hi,
    output logic [DATA_W-1:0]           pd_out,
    output logic                        pd_oe,
    input  logic [DATA_W-1:0]           pd_in,
    output logic [MODE_W-1:0]           mode,
    output logic                        hv_en,
    output logic                        pgm_strobe,
    output logic                        done,
    output logic                        err,
    output logic [ADDR_W-1:0]           err_addr
);

    localparam int ADDR_HI_W = ADDR_W - ADDR_LO_W;
    localparam int MAX_A     = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int MAX_B     = (GAP_CYC > READ_CYC) ? GAP_CYC : READ_CYC;
    localparam int MAX_WAIT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W     = $clog2(MAX_WAIT + 1);
    localparam int PCNT_W    = $clog2(NUM_PULSES + 1);

    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                last;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             tally_clr;
    logic             tally_bump;
    logic             tally_last;
    logic             rb_match;

    otp_step_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    otp_pulse_tally #(
        .N (NUM_PULSES),
        .W (PCNT_W)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tally_clr),
        .bump  (tally_bump),
        .last  (tally_last)
    );

    otp_readback_cmp #(
        .W (DATA_W)
    ) u_cmp (
        .expected (r_q.data),
        .observed (pd_in),
        .match    (rb_match)
    );

    // Next-state computation
    always_comb begin
        r_d        = r_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        tally_clr  = 1'b0;
        tally_bump = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.addr  = in_addr;
                    r_d.data  = in_data;
                    r_d.last  = in_last;
                    r_d.state = ST_ADDR;
                end
            end
            ST_ADDR: r_d.state = ST_DATA;
            ST_DATA: r_d.state = ST_CTRL;
            ST_CTRL: begin
                r_d.state = ST_SETTLE;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(SETTLE_CYC - 1);
                tally_clr = 1'b1;
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    r_d.state = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    r_d.state = ST_GAP;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(GAP_CYC - 1);
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    if (tally_last) begin
                        r_d.state = ST_HV_DROP;
                    end else begin
                        r_d.state  = ST_PULSE;
                        tally_bump = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = TMR_W'(PULSE_CYC - 1);
                    end
                end
            end
            ST_HV_DROP: r_d.state = ST_QUIET;
            ST_QUIET: begin
                r_d.state = ST_VFY;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(READ_CYC - 1);
            end
            ST_VFY: begin
                if (tmr_done) begin
                    if (!rb_match) begin
                        r_d.state = ST_ERR;
                    end else if (r_q.last) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_DONE: r_d.state = ST_DONE;
            ST_ERR:  r_d.state = ST_ERR;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, data: '0, last: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // Port decode from the registered state
    always_comb begin
        in_ready   = (r_q.state == ST_IDLE);
        pgm_strobe = (r_q.state == ST_PULSE);
        done       = (r_q.state == ST_DONE);
        err        = (r_q.state == ST_ERR);
        hv_en      = (r_q.state == ST_SETTLE) || (r_q.state == ST_PULSE) ||
                     (r_q.state == ST_GAP);
        pd_oe      = (r_q.state == ST_DATA) || (r_q.state == ST_CTRL) || hv_en ||
                     (r_q.state == ST_HV_DROP);
        if ((r_q.state == ST_CTRL) || hv_en || (r_q.state == ST_HV_DROP)) begin
            mode = MODE_PROG;
        end else if (r_q.state == ST_VFY) begin
            mode = MODE_VFY;
        end else begin
            mode = MODE_IDLE;
        end
        addr_lo  = r_q.addr[ADDR_LO_W-1:0];
        addr_hi  = r_q.addr[ADDR_W-1 -: ADDR_HI_W];
        pd_out   = r_q.data;
        err_addr = err ? r_q.addr : '0;
    end

endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk
    import otp_seq_pkg::*;
#(
    parameter int ADDR_LO_W  = 8,
    parameter int ADDR_HI_W  = 5,
    parameter int NUM_PULSES = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_ready,
    input logic [ADDR_LO_W-1:0] addr_lo,
    input logic [ADDR_HI_W-1:0] addr_hi,
    input logic [MODE_W-1:0]    mode,
    input logic                 hv_en,
    input logic                 pgm_strobe,
    input logic                 pd_oe,
    input logic                 done,
    input logic                 err
);

    localparam int CW = $clog2(NUM_PULSES + 2) + 1;

    logic          st_prev_q;
    logic [CW-1:0] rises_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_prev_q <= 1'b0;
            rises_q   <= '0;
        end else begin
            st_prev_q <= pgm_strobe;
            if (in_ready) begin
                rises_q <= '0;
            end else if (pgm_strobe && !st_prev_q) begin
                rises_q <= rises_q + 1'b1;
            end
        end
    end

    // R3
    hv_needs_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> (mode == MODE_PROG) && pd_oe);

    // R3
    hv_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> ($past(mode) == MODE_PROG));

    // R5
    strobe_under_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_strobe |-> hv_en);

    // R5
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= CW'(NUM_PULSES));

    // R5
    pulse_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hv_en) |-> (rises_q == CW'(NUM_PULSES)));

    // R6
    hv_off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MODE_PROG) && ($past(mode) == MODE_PROG)) |-> !$past(hv_en));

    // R7
    vfy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_VFY) |-> (!hv_en && !pd_oe));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !$past(in_ready)) |-> ($stable(addr_lo) && $stable(addr_hi)));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !in_ready && !err);

    // R9
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err && !hv_en && !pgm_strobe && !in_ready && !done);

endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .ADDR_LO_W  (ADDR_LO_W),
    .ADDR_HI_W  (ADDR_HI_W),
    .NUM_PULSES (NUM_PULSES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .addr_lo    (addr_lo),
    .addr_hi    (addr_hi),
    .mode       (mode),
    .hv_en      (hv_en),
    .pgm_strobe (pgm_strobe),
    .pd_oe      (pd_oe),
    .done       (done),
    .err        (err)
);

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
    import otp_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_PULSE    = 5;
    localparam int T_SETTLE   = 16;
    localparam int T_PULSE    = 10;
    localparam int T_GAP      = 4;
    localparam int T_READ     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [12:0]       in_addr = '0;
    logic [7:0]        in_data = '0;
    logic              in_last = 1'b0;
    logic [7:0]        addr_lo;
    logic [4:0]        addr_hi;
    logic [7:0]        pd_out;
    logic              pd_oe;
    logic [7:0]        pd_in;
    logic [MODE_W-1:0] mode;
    logic              hv_en;
    logic              pgm_strobe;
    logic              done;
    logic              err;
    logic [12:0]       err_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0]  mem [0:8191];
    logic [12:0] flip_addr = '0;
    logic [7:0]  flip_mask = '0;
    wire  [12:0] bus_addr = {addr_hi, addr_lo};

    otp_prog_seq #(
        .NUM_PULSES (N_PULSE),
        .SETTLE_CYC (T_SETTLE),
        .PULSE_CYC  (T_PULSE),
        .GAP_CYC    (T_GAP),
        .READ_CYC   (T_READ)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_addr    (in_addr),
        .in_data    (in_data),
        .in_last    (in_last),
        .addr_lo    (addr_lo),
        .addr_hi    (addr_hi),
        .pd_out     (pd_out),
        .pd_oe      (pd_oe),
        .pd_in      (pd_in),
        .mode       (mode),
        .hv_en      (hv_en),
        .pgm_strobe (pgm_strobe),
        .done       (done),
        .err        (err),
        .err_addr   (err_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Array model: programming can only clear bits
    initial begin
        for (int i = 0; i < 8192; i++) mem[i] = 8'hFF;
    end

    always @(posedge pgm_strobe) begin
        if (hv_en && pd_oe && mode == MODE_PROG) mem[bus_addr] = mem[bus_addr] & pd_out;
    end

    assign pd_in = (mode == MODE_VFY) ?
                   (mem[bus_addr] ^ ((bus_addr == flip_addr) ? flip_mask : 8'h00)) : 8'hFF;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // n cycles of one phase, every output compared at each negedge
    task automatic phase(input int n, input bit oe, input logic [3:0] md, input bit hv,
                         input bit st, input logic [12:0] a, input logic [7:0] d,
                         input string req, input string what);
        bit ok = 1'b1;
        logic [31:0] act = '0;
        logic [31:0] exp = '0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] a_w;
            logic [31:0] e_w;
            @(negedge clk);
            a_w = {1'b0, done | err, pd_oe, mode, hv_en, pgm_strobe, in_ready, bus_addr,
                   (oe ? pd_out : 8'h00)};
            e_w = {1'b0, 1'b0, oe, md, hv, st, 1'b0, a, (oe ? d : 8'h00)};
            if (ok && a_w != e_w) begin
                ok = 1'b0;
                act = a_w;
                exp = e_w;
            end
        end
        check(ok, req, what, act, exp);
    endtask

    // kind: 0 = back to ready, 1 = done, 2 = error
    task automatic send_byte(input logic [12:0] a, input logic [7:0] d, input bit last,
                             input bit junk, input int kind);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_data  = d;
        in_last  = last;
        @(posedge clk);
        #1;
        if (junk) begin
            in_addr = a ^ 13'h1555;
            in_data = ~d;
            in_last = ~last;
        end else begin
            in_valid = 1'b0;
        end
        phase(1, 1'b0, MODE_IDLE, 1'b0, 1'b0, a, d, "R3", "address phase");
        phase(1, 1'b1, MODE_IDLE, 1'b0, 1'b0, a, d, "R3", "data phase");
        phase(1, 1'b1, MODE_PROG, 1'b0, 1'b0, a, d, "R3", "mode phase");
        phase(T_SETTLE, 1'b1, MODE_PROG, 1'b1, 1'b0, a, d, "R4", "settle wait");
        for (int p = 0; p < N_PULSE; p++) begin
            phase(T_PULSE, 1'b1, MODE_PROG, 1'b1, 1'b1, a, d, "R5", "strobe high");
            phase(T_GAP, 1'b1, MODE_PROG, 1'b1, 1'b0, a, d, "R5", "strobe gap");
        end
        phase(1, 1'b1, MODE_PROG, 1'b0, 1'b0, a, d, "R6", "voltage drop");
        phase(1, 1'b0, MODE_IDLE, 1'b0, 1'b0, a, d, "R6", "mode idle");
        phase(T_READ, 1'b0, MODE_VFY, 1'b0, 1'b0, a, d, "R7", "read-back window");
        @(negedge clk);
        in_valid = 1'b0;
        if (kind == 0) begin
            check(in_ready && !done && !err, "R8", "ready after match",
                  {29'd0, in_ready, done, err}, 32'b100);
            check(bus_addr == a, "R2", "address unaffected by busy inputs", bus_addr, a);
        end else if (kind == 1) begin
            check(done && !in_ready && !err, "R8", "done after last byte",
                  {29'd0, in_ready, done, err}, 32'b010);
        end else begin
            check(err && !in_ready && !done, "R9", "error on mismatch",
                  {29'd0, in_ready, done, err}, 32'b001);
            check(err_addr == a, "R9", "failing address", err_addr, a);
        end
    endtask

    task automatic apply_reset();
        bit ok = 1'b1;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        ok = in_ready && mode == MODE_IDLE && !hv_en && !pgm_strobe && !pd_oe && !done && !err;
        check(ok, "R1", "outputs during reset",
              {24'd0, in_ready, mode, hv_en, pgm_strobe, pd_oe}, {24'd0, 1'b1, MODE_IDLE, 3'b000});
        rst_n = 1'b1;
        @(negedge clk);
        ok = in_ready && mode == MODE_IDLE && !hv_en && !pgm_strobe && !pd_oe && !done && !err;
        check(ok, "R1", "outputs after reset",
              {24'd0, in_ready, mode, hv_en, pgm_strobe, pd_oe}, {24'd0, 1'b1, MODE_IDLE, 3'b000});
    endtask

    task automatic t_idle_hold();
        bit ok = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (!in_ready || hv_en || pgm_strobe || mode != MODE_IDLE) ok = 1'b0;
        end
        check(ok, "R2", "no activity without a valid byte", {31'd0, ok}, 32'd1);
    endtask

    task automatic t_single_low();
        send_byte(13'h0000, 8'h3C, 1'b0, 1'b0, 0);
        check(mem[13'h0000] == 8'h3C, "R5", "byte written at low edge", mem[13'h0000], 8'h3C);
    endtask

    task automatic t_busy_junk_high();
        send_byte(13'h1FFF, 8'hA5, 1'b0, 1'b1, 0);
        check(mem[13'h1FFF] == 8'hA5, "R2", "byte written at top address", mem[13'h1FFF], 8'hA5);
    endtask

    task automatic t_last_done();
        bit ok = 1'b1;
        send_byte(13'h0100, 8'h00, 1'b1, 1'b0, 1);
        in_valid = 1'b1;
        in_addr  = 13'h0222;
        in_data  = 8'h11;
        repeat (20) begin
            @(negedge clk);
            if (!done || in_ready || pgm_strobe || hv_en || bus_addr != 13'h0100) ok = 1'b0;
        end
        in_valid = 1'b0;
        check(ok, "R8", "done holds and ignores input", {31'd0, ok}, 32'd1);
    endtask

    task automatic t_mismatch();
        bit ok = 1'b1;
        flip_addr = 13'h0A5A;
        flip_mask = 8'h10;
        send_byte(13'h0A59, 8'h77, 1'b0, 1'b0, 0);
        send_byte(13'h0A5A, 8'h12, 1'b1, 1'b0, 2);
        in_valid = 1'b1;
        in_addr  = 13'h0333;
        repeat (30) begin
            @(negedge clk);
            if (!err || in_ready || pgm_strobe || hv_en || err_addr != 13'h0A5A) ok = 1'b0;
        end
        in_valid  = 1'b0;
        flip_mask = 8'h00;
        check(ok, "R9", "stopped after error", {31'd0, ok}, 32'd1);
    endtask

    initial begin
        apply_reset();
        t_idle_hold();
        t_single_low();
        t_busy_junk_high();
        t_last_done();
        apply_reset();
        t_mismatch();
        apply_reset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule